// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block turns a two-channel PCM bit stream into parallel samples. The stream has three lines: a bit clock, a word clock that marks which channel is being sent, and a serial data line. All three lines are brought into the system clock domain through synchronizer flops. A rising edge of the bit clock is detected in that domain and used as a sampling enable. Each completed word is sign-extended to 24 bits. The left and right words of one frame are presented together, with a one-cycle valid strobe.

Three static control inputs set the framing. The first picks right-justified or I2S alignment. The second picks a word length of 16, 20 or 24 bits. The third sets which word-clock level means the left channel. A separate flag rises when the data line has been sampled low on a configurable number of consecutive bit clocks. A downstream mute can use this flag.

Top module: `audio_rx`

## Requirements
- R1: While rst_ni is low, and after its release until the first frame completes, left_o and right_o are zero and valid_o and zero_o are low.
- R2: Data is sampled on rising edges of bck_i and arrives MSB first in two's complement. Each captured word is sign-extended from its length to 24 bits.
- R3: With fmt_i2s_i = 0 (right-justified), a word consists of the last N bits sampled before the word clock changes level. Bits earlier in that half-period are ignored.
- R4: With fmt_i2s_i = 1 (I2S), the first bit sampled after a word-clock change is ignored. The next N bits form the word, MSB first, and any later bits in that half-period are ignored.
- R5: wlen_i selects N: 2'b00 gives 16, 2'b01 gives 20, 2'b10 gives 24. The reserved code 2'b11 is treated as 16.
- R6: With lr_pol_i = 0, a high word clock carries the left channel and a low one carries the right. With lr_pol_i = 1, the two are swapped.
- R7: Completing a right-channel word (seen when the word clock next changes) raises valid_o for exactly one clk_i cycle. In that cycle the frame's left and right words are on left_o and right_o. The outputs hold their value at all other times, and each complete frame gives exactly one strobe.
- R8: zero_o goes high once ZERO_LIMIT consecutive samples of the data line are zero. It stays low after ZERO_LIMIT-1 such samples, and it returns low after any sample of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bck_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Word clock (channel select) |
| sdata_i | input | 1 | Serial audio data |
| fmt_i2s_i | input | 1 | 0 = right-justified, 1 = I2S |
| lr_pol_i | input | 1 | Word-clock polarity swap |
| wlen_i | input | 2 | Word length code |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle frame strobe |
| zero_o | output | 1 | Continuous-zero flag |

## Verification
A bit-clock rise is seen in the clk_i domain two cycles after it happens, because of the synchronizer. The captured word and valid_o follow one cycle after that. zero_o also updates in that same cycle, three clk_i cycles after the rise. The stimulus holds each bit-clock level for four clk_i cycles. It checks zero_o only after the task that drove the bit has returned, which is four cycles after the rise. Frame results are checked by a monitor on the falling clk_i edge: it waits for valid_o and compares against a queue of expected frames, so no fixed latency is assumed.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = 6;

  function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'b01:   return CNT_W'(20);
      2'b10:   return CNT_W'(24);
      default: return CNT_W'(16);  // 2'b11 reserved -> 16
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] raw,
                                               input logic [CNT_W-1:0] n);
    case (n)
      CNT_W'(24): return raw;
      CNT_W'(20): return {{4{raw[19]}}, raw[19:0]};
      default:    return {{8{raw[15]}}, raw[15:0]};
    endcase
  endfunction
endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '0;
      else         pipe <= {pipe[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/audio_rx_deframe.sv
module audio_rx_deframe
  import audio_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic                sdata_i,
  input  logic                lrck_i,
  input  logic                fmt_i2s_i,
  input  logic                lr_pol_i,
  input  logic [1:0]          wlen_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                primed, lr_q, valid_q;
  logic [CNT_W-1:0]    cnt_q, nbits;
  logic [SAMPLE_W-1:0] shreg, word, left_hold, left_q, right_q;
  logic                new_half, was_left, shift_en;

  assign nbits    = wlen_bits(wlen_i);
  assign new_half = !primed || (lrck_i != lr_q);
  assign word     = sext(shreg, nbits);
  assign was_left = lr_q ^ lr_pol_i;
  // I2S: slot 0 after the edge is skipped, slots 1..N are the word
  assign shift_en = fmt_i2s_i ? (!new_half && cnt_q != '0 && cnt_q <= nbits) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed    <= 1'b0;
      lr_q      <= 1'b0;
      cnt_q     <= '0;
      shreg     <= '0;
      left_hold <= '0;
      left_q    <= '0;
      right_q   <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (rise_i) begin
        primed <= 1'b1;
        lr_q   <= lrck_i;
        if (new_half) begin
          cnt_q <= CNT_W'(1);
          if (primed) begin
            if (was_left) left_hold <= word;
            else begin
              left_q  <= left_hold;
              right_q <= word;
              valid_q <= 1'b1;
            end
          end
        end else if (cnt_q != CNT_MAX) begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (shift_en) shreg <= {shreg[SAMPLE_W-2:0], sdata_i};
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  assert_valid_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_valid_after_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rise_i));
  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(right_o) && $stable(left_o)));
  assert_i2s_skip_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && fmt_i2s_i && primed && lrck_i != lr_q) |=> $stable(shreg));
endmodule

// File: rtl/audio_rx_zero.sv
module audio_rx_zero #(
  parameter int LIMIT = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic sdata_i,
  output logic zero_o
);
  localparam int            CW  = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (rise_i) begin
      if (sdata_i)               run_q <= '0;
      else if (run_q != LIM)     run_q <= run_q + 1'b1;
    end
  end

  assign zero_o = (run_q == LIM);

  assert_zero_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && sdata_i) |=> !zero_o);
  assert_zero_rise_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(zero_o) |-> $past(rise_i && !sdata_i));
endmodule

// File: rtl/audio_rx.sv
module audio_rx
  import audio_rx_pkg::*;
#(
  parameter int ZERO_LIMIT  = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bck_i,
  input  logic        lrck_i,
  input  logic        sdata_i,
  input  logic        fmt_i2s_i,
  input  logic        lr_pol_i,
  input  logic [1:0]  wlen_i,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o,
  output logic        zero_o
);
  logic [2:0] s_vec;
  logic       bck_q, rise;

  audio_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sdata_i, lrck_i, bck_i}),
    .sync_o  (s_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bck_q <= 1'b0;
    else         bck_q <= s_vec[0];
  end
  assign rise = s_vec[0] & ~bck_q;

  audio_rx_deframe u_deframe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .sdata_i   (s_vec[2]),
    .lrck_i    (s_vec[1]),
    .fmt_i2s_i (fmt_i2s_i),
    .lr_pol_i  (lr_pol_i),
    .wlen_i    (wlen_i),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

  audio_rx_zero #(.LIMIT(ZERO_LIMIT)) u_zero (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .sdata_i (s_vec[2]),
    .zero_o  (zero_o)
  );
endmodule

// File: tb/audio_rx_tb.sv
module audio_rx_tb;
  localparam int HALF  = 32;
  localparam int ZLIM  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bck = 1'b0, lrck = 1'b1, sdata = 1'b0;
  logic        fmt = 1'b0, pol = 1'b0;
  logic [1:0]  wl = 2'b00;
  logic [23:0] left, right;
  logic        valid, zero;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R2";
  logic [47:0] exp_q[$];

  always #5 clk = ~clk;

  audio_rx #(.ZERO_LIMIT(ZLIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bck_i(bck), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_i2s_i(fmt), .lr_pol_i(pol), .wlen_i(wl),
    .left_o(left), .right_o(right), .valid_o(valid), .zero_o(zero)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int wlen_n(input logic [1:0] c);
    return (c == 2'b01) ? 20 : (c == 2'b10) ? 24 : 16;
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] v, input int n);
    logic signed [23:0] t;
    t = v << (24 - n);
    return t >>> (24 - n);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected strobe", {left, right}, '0);
      else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        chk({left, right} == e, cur_tag, {left, right}, e);
      end
    end
  end

  task automatic drive_bit(input logic lv, input logic d);
    @(negedge clk); lrck = lv; sdata = d;
    repeat (4) @(negedge clk); bck = 1'b1;
    repeat (4) @(negedge clk); bck = 1'b0;
  endtask

  task automatic send_half(input logic lv, input logic [23:0] v, input int n);
    for (int i = 0; i < HALF; i++) begin
      logic b;
      if (fmt) b = (i >= 1 && i <= n) ? v[n - i] : 1'b1;
      else     b = (i >= HALF - n) ? v[HALF - 1 - i] : 1'b1;
      drive_bit(lv, b);
    end
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r);
    int n;
    logic lv;
    n  = wlen_n(wl);
    lv = ~pol;
    exp_q.push_back({sx(l, n), sx(r, n)});
    send_half(lv, l, n);
    send_half(~lv, r, n);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bck = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run_group(input logic f, input logic p, input logic [1:0] w, input string tag);
    do_reset();
    fmt = f; pol = p; wl = w; cur_tag = tag;
    send_frame(24'h800000 | 24'h008000 | 24'h080000, 24'h7FFFFF);
    send_frame(24'hFFFFFF, 24'h000001);
    for (int k = 0; k < 2; k++) send_frame($urandom, $urandom);
    drive_bit(~pol, 1'b0);
    drive_bit(~pol, 1'b0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7 one strobe per frame", 48'(exp_q.size()), 48'd0);
    exp_q.delete();
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    chk(left == 0 && right == 0 && !valid && !zero, "R1 reset state",
        {left, right}, 48'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(left == 0 && right == 0 && !valid && !zero, "R1 after release",
        {left, right}, 48'd0);

    run_group(1'b0, 1'b0, 2'b00, "R3 rj 16 (R2)");
    run_group(1'b0, 1'b0, 2'b01, "R5 rj 20");
    run_group(1'b0, 1'b0, 2'b10, "R5 rj 24");
    run_group(1'b0, 1'b0, 2'b11, "R5 reserved as 16");
    run_group(1'b1, 1'b0, 2'b00, "R4 i2s 16");
    run_group(1'b1, 1'b0, 2'b10, "R4 i2s 24");
    run_group(1'b0, 1'b1, 2'b10, "R6 swapped rj 24");
    run_group(1'b1, 1'b1, 2'b01, "R6 swapped i2s 20");

    // R8 zero run, word clock held constant
    do_reset();
    fmt = 1'b0; pol = 1'b0; wl = 2'b00;
    drive_bit(1'b1, 1'b1);
    for (int i = 0; i < ZLIM - 1; i++) drive_bit(1'b1, 1'b0);
    chk(!zero, "R8 below limit", 48'(zero), 48'd0);
    drive_bit(1'b1, 1'b0);
    chk(zero, "R8 at limit", 48'(zero), 48'd1);
    drive_bit(1'b1, 1'b0);
    chk(zero, "R8 held", 48'(zero), 48'd1);
    drive_bit(1'b1, 1'b1);
    chk(!zero, "R8 cleared by one", 48'(zero), 48'd0);
    chk(!valid && left == 0, "R7 no strobe without word clock change", {left, right}, 48'd0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule